// File: doc/BRIEF.md
# Flash write-status polling logic

This block produces the byte a nonvolatile memory places on its data bus while an internal program or erase runs, and while it settles afterwards. Software finds out whether the write has finished by reading ordinary locations. During an operation, bit 7 of every read carries a polarity flag and bit 6 flips on each read. Once the operation ends and the outputs have settled, reads return the stored data unchanged.

A one-cycle start pulse launches an operation. The start carries the operation kind, a busy length in clock cycles, and the most significant bit of the byte being programmed. A programmable down-counter stands in for the real array timing. A second counter models the interval after a program during which only bit 7 can be trusted.

An active-low reset pin is honoured only after it has been low for a minimum number of cycles. Once honoured, it aborts the running operation, signals that the array contents may be corrupt, and disables the data bus drivers.

Top module: `flash_wstat`

## Requirements
- R1: After the synchronous block reset `rst_n`, `busy`, `bus_oe`, `aborted` and `bus_q` are all 0.
- R2: A start pulse accepted while idle raises `busy` in the next cycle. `busy` then stays high for `op_len` cycles, or for 1 cycle when `op_len` is 0.
- R3: A read while a program is busy returns bit 7 as the complement of `prog_bit7` and bits 5..0 as ones.
- R4: A read while an erase is busy returns bit 7 as 0. After the erase ends, reads return `arr_data` at once, with no settling interval.
- R5: Bit 6 of a busy-period read is 0 on the first read of each operation and inverts on every later read. Clock cycles without a read strobe leave it unchanged.
- R6: For `SETTLE_CYC` cycles after a program's busy period ends, a read returns `arr_data[7]` in bit 7 and ones in bits 6..0. After that, reads return `arr_data`, and two back-to-back reads return the same value.
- R7: A start pulse while `busy` is high is ignored. The running operation keeps its kind, its programmed bit and its remaining length.
- R8: The reset pin held low for fewer than `RST_MIN` consecutive cycles has no effect.
- R9: The reset pin held low for `RST_MIN` consecutive cycles is honoured. It clears `busy` one cycle later and pulses `aborted` for one cycle if an operation was busy or settling. While the pin stays low, reads leave `bus_oe` at 0 and start pulses are ignored.
- R10: A read while idle returns `arr_data`, with `bus_oe` high in the cycle after the strobe only. `bus_oe` is 0 in every cycle not preceded by a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_pin_n | input | 1 | Modelled device reset pin, active low, pulse-width filtered |
| op_start | input | 1 | One-cycle request to begin an internal operation |
| op_kind | input | 1 | Operation kind: 0 program, 1 erase |
| op_len | input | LEN_W | Busy length in clock cycles |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed |
| arr_data | input | 8 | True contents of the location being read |
| rd_stb | input | 1 | One-cycle read strobe |
| busy | output | 1 | Internal operation in progress |
| bus_q | output | 8 | Byte driven on the data bus |
| bus_oe | output | 1 | Data bus driver enable (0 = high impedance) |
| aborted | output | 1 | One-cycle pulse: an operation was cut short by reset |

## Verification
A program is polled with a stored bit 7 of 0, so a busy read gives 1 in bit 7 and a finished read gives 0. This separates an inverted bit from a passed-through one. An erase is polled over a location of all ones, which separates the forced 0 from the true data. Reads are spaced with idle cycles and repeated across two operations, which shows whether bit 6 moves only on reads and restarts at 0. The settle window is probed on its last cycle and the cycle after. Reset pulses of `RST_MIN`-1 and `RST_MIN` cycles, and a start issued in mid-operation, show where each edge of the filter and the start guard lies.

// File: rtl/flash_wstat_pkg.sv
// Package: shared types for the write-status polling logic.
// Assumes an 8-bit data bus; bit 7 is the polarity flag, bit 6 the toggle flag.
package flash_wstat_pkg;
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    localparam int DATA_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
endpackage

// File: rtl/wstat_rst_filter.sv
// Module: wstat_rst_filter
// Qualifies the active-low reset pin: hold rises only after the pin has
// been sampled low on RST_MIN consecutive clock edges, and falls in the
// cycle after the pin is seen high. Assumes RST_MIN >= 1.
module wstat_rst_filter #(
    parameter int RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic hold
);
    localparam int CW = $clog2(RST_MIN + 2);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples and raise hold at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            hold    <= 1'b0;
        end else if (pin_n) begin
            low_cnt <= '0;
            hold    <= 1'b0;
        end else begin
            if (low_cnt != CW'(RST_MIN))
                low_cnt <= low_cnt + 1'b1;
            hold <= (low_cnt >= CW'(RST_MIN - 1));
        end
    end

    // R8: a high pin always releases the filter in the next cycle
    a_r8_pin_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
        pin_n |=> !hold);

    // R9: hold can only appear after the pin was low
    a_r9_hold_needs_low_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> !$past(pin_n));
endmodule

// File: rtl/wstat_op_timer.sv
// Module: wstat_op_timer
// Tracks one internal operation: accepts a start when idle and not held in
// reset, counts the busy length down, then runs a settle window after a
// program. An honoured reset aborts both and pulses 'aborted'.
// Assumes op_len is stable during the start pulse.
module wstat_op_timer
    import flash_wstat_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int SETTLE_CYC = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             op_start,
    input  logic             op_kind,
    input  logic [LEN_W-1:0] op_len,
    input  logic             prog_bit7,
    output logic             busy,
    output logic             settling,
    output op_kind_e         kind_q,
    output logic             pbit7_q,
    output logic             op_begin,
    output logic             aborted
);
    localparam int SW = $clog2(SETTLE_CYC + 2);

    logic [LEN_W-1:0] busy_cnt;
    logic [SW-1:0]    settle_cnt;

    assign busy     = (busy_cnt != '0);
    assign settling = (settle_cnt != '0);
    assign op_begin = op_start && !busy && !hold;

    // Operation state: start, busy countdown, settle countdown, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt   <= '0;
            settle_cnt <= '0;
            kind_q     <= OP_PROG;
            pbit7_q    <= 1'b0;
            aborted    <= 1'b0;
        end else if (hold) begin
            busy_cnt   <= '0;
            settle_cnt <= '0;
            aborted    <= busy || settling;
        end else begin
            aborted <= 1'b0;
            if (op_begin) begin
                busy_cnt   <= (op_len == '0) ? LEN_W'(1) : op_len;
                kind_q     <= op_kind_e'(op_kind);
                pbit7_q    <= prog_bit7;
                settle_cnt <= '0;
            end else if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
                if (busy_cnt == LEN_W'(1) && kind_q == OP_PROG)
                    settle_cnt <= SW'(SETTLE_CYC);
            end else if (settling) begin
                settle_cnt <= settle_cnt - 1'b1;
            end
        end
    end

    // R2: an accepted start makes the block busy next cycle
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy && !hold) |=> busy);

    // R7: a running operation keeps its kind and programmed bit
    a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hold) |=> ($stable(kind_q) && $stable(pbit7_q)));

    // R9: an honoured reset leaves nothing running
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!busy && !settling));

    // R6: the settle window follows only a program
    a_r6_settle_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settling) |-> (kind_q == OP_PROG));
endmodule

// File: rtl/wstat_status_mux.sv
// Module: wstat_status_mux
// Builds the byte returned on a read: polarity and toggle flags while busy,
// a bit-7-only view while settling, true data otherwise. Holds the toggle
// flip-flop and registers the bus value and driver enable.
// Assumes rd_stb is a one-cycle strobe per read.
module wstat_status_mux
    import flash_wstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              rd_stb,
    input  logic              busy,
    input  logic              settling,
    input  op_kind_e          kind_q,
    input  logic              pbit7_q,
    input  logic              op_begin,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_oe
);
    logic              tog_q;
    logic [DATA_W-1:0] rd_val;

    // Toggle flag: cleared per operation, inverted by each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog_q <= 1'b0;
        else if (hold || op_begin)
            tog_q <= 1'b0;
        else if (rd_stb && busy)
            tog_q <= ~tog_q;
    end

    // Select what a read returns in the present state.
    always_comb begin
        rd_val = arr_data;
        if (busy) begin
            rd_val           = '1;
            rd_val[POLL_BIT] = (kind_q == OP_ERASE) ? 1'b0 : ~pbit7_q;
            rd_val[TOG_BIT]  = tog_q;
        end else if (settling) begin
            rd_val           = '1;
            rd_val[POLL_BIT] = arr_data[POLL_BIT];
        end
    end

    // Register the bus byte and its driver enable per read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q  <= '0;
            bus_oe <= 1'b0;
        end else if (hold) begin
            bus_oe <= 1'b0;
        end else if (rd_stb) begin
            bus_q  <= rd_val;
            bus_oe <= 1'b1;
        end else begin
            bus_oe <= 1'b0;
        end
    end

    // R5: without a read or new operation the toggle flag holds
    a_r5_toggle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !op_begin && !hold) |=> $stable(tog_q));

    // R9: drivers are off while reset is honoured
    a_r9_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !bus_oe);

    // R10: the bus is driven only after a read strobe
    a_r10_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(rd_stb));

    // R4: an erase in progress reads bit 7 as 0
    a_r4_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && kind_q == OP_ERASE && !hold) |=> (bus_q[POLL_BIT] == 1'b0));

    // R3: a program in progress reads bit 7 inverted
    a_r3_prog_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && kind_q == OP_PROG && !hold) |=> (bus_q[POLL_BIT] != $past(pbit7_q)));
endmodule

// File: rtl/flash_wstat.sv
// Module: flash_wstat (top)
// Write-status polling logic: connects the reset-pin filter, the operation
// timer and the read-value selector. Assumes all inputs are synchronous to clk.
module flash_wstat
    import flash_wstat_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int SETTLE_CYC = 50,
    parameter int RST_MIN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin_n,
    input  logic              op_start,
    input  logic              op_kind,
    input  logic [LEN_W-1:0]  op_len,
    input  logic              prog_bit7,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              rd_stb,
    output logic              busy,
    output logic [DATA_W-1:0] bus_q,
    output logic              bus_oe,
    output logic              aborted
);
    logic     hold;
    logic     settling;
    logic     pbit7_q;
    logic     op_begin;
    op_kind_e kind_q;

    wstat_rst_filter #(.RST_MIN(RST_MIN)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (rst_pin_n),
        .hold  (hold)
    );

    wstat_op_timer #(.LEN_W(LEN_W), .SETTLE_CYC(SETTLE_CYC)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_len    (op_len),
        .prog_bit7 (prog_bit7),
        .busy      (busy),
        .settling  (settling),
        .kind_q    (kind_q),
        .pbit7_q   (pbit7_q),
        .op_begin  (op_begin),
        .aborted   (aborted)
    );

    wstat_status_mux mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .rd_stb   (rd_stb),
        .busy     (busy),
        .settling (settling),
        .kind_q   (kind_q),
        .pbit7_q  (pbit7_q),
        .op_begin (op_begin),
        .arr_data (arr_data),
        .bus_q    (bus_q),
        .bus_oe   (bus_oe)
    );
endmodule

// File: tb/flash_wstat_tb_top.sv
// Directed bench for flash_wstat: one task per scenario, each checking itself.
module flash_wstat_tb_top;
    localparam int LEN_W      = 16;
    localparam int SETTLE_CYC = 50;
    localparam int RST_MIN    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rst_pin_n = 1'b1;
    logic             op_start = 1'b0;
    logic             op_kind = 1'b0;
    logic [LEN_W-1:0] op_len = '0;
    logic             prog_bit7 = 1'b0;
    logic [7:0]       arr_data = 8'h00;
    logic             rd_stb = 1'b0;
    logic             busy;
    logic [7:0]       bus_q;
    logic             bus_oe;
    logic             aborted;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_wstat #(.LEN_W(LEN_W), .SETTLE_CYC(SETTLE_CYC), .RST_MIN(RST_MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .op_start(op_start),
        .op_kind(op_kind), .op_len(op_len), .prog_bit7(prog_bit7),
        .arr_data(arr_data), .rd_stb(rd_stb), .busy(busy), .bus_q(bus_q),
        .bus_oe(bus_oe), .aborted(aborted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] q, output logic oe);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        q  = bus_q;
        oe = bus_oe;
    endtask

    task automatic start_op(input logic kind, input int len, input logic b7);
        op_start  = 1'b1;
        op_kind   = kind;
        op_len    = LEN_W'(len);
        prog_bit7 = b7;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic wait_quiet();
        while (busy) @(negedge clk);
        tick(SETTLE_CYC + 2);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 bus_q", bus_q, 0);
        chk("R1 aborted", aborted, 0);
    endtask

    task automatic t_idle_read();
        logic [7:0] q; logic oe;
        arr_data = 8'h5A;
        do_read(q, oe);
        chk("R10 idle data", q, 8'h5A);
        chk("R10 oe after read", oe, 1);
        tick(1);
        chk("R10 oe without read", bus_oe, 0);
    endtask

    task automatic t_length();
        int n = 0;
        start_op(1'b1, 7, 1'b0);
        while (busy) begin n++; @(negedge clk); end
        chk("R2 busy length 7", n, 7);
        n = 0;
        start_op(1'b1, 0, 1'b0);
        while (busy) begin n++; @(negedge clk); end
        chk("R2 busy length for 0", n, 1);
        tick(2);
    endtask

    task automatic t_program();
        logic [7:0] q; logic oe;
        arr_data = 8'h43;
        start_op(1'b0, 30, 1'b0);
        chk("R2 busy after start", busy, 1);
        do_read(q, oe);
        chk("R3 R5 first busy read", q, 8'hBF);
        tick(3);
        do_read(q, oe);
        chk("R5 second read toggled", q, 8'hFF);
        do_read(q, oe);
        chk("R5 third read toggled back", q, 8'hBF);
        while (busy) @(negedge clk);
        do_read(q, oe);
        chk("R6 settle start", q, 8'h43 | 8'h7F);
        tick(SETTLE_CYC - 2);
        do_read(q, oe);
        chk("R6 last settle cycle", q, 8'h7F);
        do_read(q, oe);
        chk("R6 first true read", q, 8'h43);
        do_read(q, oe);
        chk("R6 second true read", q, 8'h43);
    endtask

    task automatic t_erase();
        logic [7:0] q; logic oe;
        arr_data = 8'hFF;
        start_op(1'b1, 20, 1'b1);
        do_read(q, oe);
        chk("R4 R5 erase first read", q, 8'h3F);
        do_read(q, oe);
        chk("R4 erase second read", q, 8'h7F);
        while (busy) @(negedge clk);
        do_read(q, oe);
        chk("R4 erase done data", q, 8'hFF);
        tick(2);
    endtask

    task automatic t_ignore_start();
        logic [7:0] q; logic oe;
        int n = 0;
        arr_data = 8'h00;
        start_op(1'b0, 10, 1'b0);
        start_op(1'b1, 100, 1'b1);
        do_read(q, oe);
        chk("R7 kind kept", q[7], 1);
        while (busy) begin n++; @(negedge clk); end
        chk("R7 length kept", n, 8);
        wait_quiet();
    endtask

    task automatic t_short_reset();
        start_op(1'b0, 20, 1'b0);
        rst_pin_n = 1'b0;
        tick(RST_MIN - 1);
        rst_pin_n = 1'b1;
        tick(1);
        chk("R8 busy kept", busy, 1);
        chk("R8 no abort", aborted, 0);
        wait_quiet();
    endtask

    task automatic t_long_reset();
        logic [7:0] q; logic oe;
        start_op(1'b0, 40, 1'b0);
        tick(2);
        rst_pin_n = 1'b0;
        tick(RST_MIN);
        chk("R9 busy before honour", busy, 1);
        tick(1);
        chk("R9 busy aborted", busy, 0);
        chk("R9 abort pulse", aborted, 1);
        tick(1);
        chk("R9 abort pulse ends", aborted, 0);
        do_read(q, oe);
        chk("R9 bus released", oe, 0);
        start_op(1'b0, 5, 1'b0);
        chk("R9 start ignored", busy, 0);
        rst_pin_n = 1'b1;
        tick(1);
        arr_data = 8'h3C;
        do_read(q, oe);
        chk("R10 read after release", q, 8'h3C);
        chk("R10 oe after release", oe, 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_idle_read();
        t_length();
        t_program();
        t_erase();
        t_ignore_start();
        t_short_reset();
        t_long_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule